// File: doc/BRIEF.md
# Real-Time-Clock Alarm Match and Interrupt

This block watches the calendar time held by a real-time clock and signals the host when that time reaches a programmed alarm. Six alarm bytes cover seconds, minutes, hours, day of month, month and weekday. There is no alarm byte for the year. The top bit of each alarm byte is an enable for that field, and the low seven bits hold a BCD value laid out like the matching time field. The comparison runs only on the one-second update strobe that comes with each new time value. A match needs at least one field enabled, and every enabled field must equal its time field.

On a match the block sets an alarm flag. The shared active-low interrupt pin then does one of two things, selected by a mode bit:
- In latched mode the pin stays low until the flag is cleared. The host clears it by writing a zero to the flag bit. If the auto-clear bit is set, reading the status byte also clears it.
- In pulse mode every match drives the pin low for a fixed number of clock cycles. The flag is still set but does not need servicing.

When the frequency-output enable is high, the pin carries the frequency signal instead of the alarm.

A small byte-wide port writes and reads back the alarm bytes, the mode bit, the auto-clear bit and the flag. The time counter itself lies outside this block and arrives as a bus of seven-bit fields.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset all alarm enables, the mode bit, the auto-clear bit and the flag read as 0, every register reads 0, and `irq_n` is 1.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 weekday, 6 control (bit 0 = pulse mode) and 7 status (bit 7 = auto-clear, bit 0 = flag). Each address reads back what was written, with unused bits reading 0. `rd_data` is valid one cycle after `rd_en`.
- R3: A match needs `tick` high. Every alarm byte with bit 7 set must have bits 6:0 equal to its time field, and fields with bit 7 clear are ignored. The flag is set at the clock edge that samples that `tick`.
- R4: With no alarm byte enabled, no tick ever produces a match.
- R5: In latched mode (control bit 0 = 0) with frequency output off, `irq_n` is 0 right after the matching edge. It stays 0 across later ticks until the flag is cleared.
- R6: A write to status with bit 0 = 0 clears the flag, and `irq_n` returns to 1 after that edge. A write with bit 0 = 1 leaves the flag unchanged.
- R7: When auto-clear is 1, a status read returns the flag as 1 and clears it. When auto-clear is 0, a status read leaves the flag set.
- R8: In pulse mode each match drives `irq_n` to 0 for exactly `PULSE_CYC` cycles and also sets the flag. A further match pulses again without the flag being cleared.
- R9: With `fout_en` high, `irq_n` equals the `fout_in` value sampled one edge earlier. A match still sets the flag.
- R10: If a match and a flag-clearing write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a status read may auto-clear the flag) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| tick | input | 1 | One-second time update strobe |
| tod | input | 42 | Time fields, 7 bits each, seconds in bits 6:0 up to weekday in bits 41:35 |
| fout_en | input | 1 | Frequency output owns the pin |
| fout_in | input | 1 | Frequency signal routed to the pin |
| irq_n | output | 1 | Registered active-low interrupt / frequency pin |

## Verification
`irq_n` is registered from next-state values, so the effect of a tick, a write, a status read or an `fout_in` change shows up right after the edge that samples it. The bench drives each stimulus for one cycle from a falling edge and checks the pin at the next falling edge. Read data follows the same one-edge timing and is sampled at the falling edge after `rd_en`. A pulse-mode pulse is measured by counting low samples over the following falling edges.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD = 6;
  localparam int VAL_W  = 7;
  localparam int ADDR_W = 3;
  localparam int DATA_W = VAL_W + 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd7;

  typedef struct packed {
    logic             en;
    logic [VAL_W-1:0] val;
  } alarm_byte_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    alm,
  output logic [DATA_W-1:0]       rd_data,
  output alarm_byte_t [NFIELD-1:0] abytes,
  output logic                    im,
  output logic                    arst,
  output logic                    stat_rd,
  output logic                    clr_req,
  output logic                    any_en
);
  logic stat_wr;

  assign stat_wr = wr_en && (wr_addr == ADR_STAT);
  assign stat_rd = rd_en && (rd_addr == ADR_STAT);
  assign clr_req = stat_wr && !wr_data[0];

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) abytes[g] <= '0;
        else if (wr_en && (wr_addr == ADDR_W'(g))) abytes[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      im   <= 1'b0;
      arst <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == ADR_CTRL)) im <= wr_data[0];
      if (stat_wr) arst <= wr_data[DATA_W-1];
    end
  end

  always_comb begin
    any_en = 1'b0;
    for (int i = 0; i < NFIELD; i++) any_en = any_en | abytes[i].en;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (rd_addr == ADR_CTRL)      rd_data <= {{(DATA_W-1){1'b0}}, im};
      else if (rd_addr == ADR_STAT) rd_data <= {arst, {(DATA_W-2){1'b0}}, alm};
      else                          rd_data <= abytes[rd_addr];
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic                     tick,
  input  logic [NFIELD*VAL_W-1:0]  tod,
  input  alarm_byte_t [NFIELD-1:0] abytes,
  output logic                     match
);
  logic [NFIELD-1:0] hit;
  logic [NFIELD-1:0] ens;

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_cmp
      assign ens[g] = abytes[g].en;
      assign hit[g] = !abytes[g].en || (abytes[g].val == tod[g*VAL_W +: VAL_W]);
    end
  endgenerate

  assign match = tick && (|ens) && (&hit);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic im,
  input  logic arst,
  input  logic stat_rd,
  input  logic clr_req,
  input  logic fout_en,
  input  logic fout_in,
  output logic alm,
  output logic irq_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic          alm_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    alm_nxt = match || (alm && !clr_req && !(arst && stat_rd));
    if (match && im)   cnt_nxt = CW'(PULSE_CYC);
    else if (cnt != 0) cnt_nxt = cnt - CW'(1);
    else               cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alm   <= 1'b0;
      cnt   <= '0;
      irq_n <= 1'b1;
    end else begin
      alm <= alm_nxt;
      cnt <= cnt_nxt;
      if (fout_en)  irq_n <= fout_in;
      else if (im)  irq_n <= (cnt_nxt == '0);
      else          irq_n <= !alm_nxt;
    end
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [2:0]              wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    rd_en,
  input  logic [2:0]              rd_addr,
  output logic [7:0]              rd_data,
  input  logic                    tick,
  input  logic [41:0]             tod,
  input  logic                    fout_en,
  input  logic                    fout_in,
  output logic                    irq_n
);
  alarm_byte_t [NFIELD-1:0] abytes;
  logic im, arst, stat_rd, clr_req, any_en, match, alm;

  alarm_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .alm(alm), .rd_data(rd_data),
    .abytes(abytes), .im(im), .arst(arst), .stat_rd(stat_rd),
    .clr_req(clr_req), .any_en(any_en)
  );

  alarm_match u_match (
    .tick(tick), .tod(tod), .abytes(abytes), .match(match)
  );

  irq_ctrl #(.PULSE_CYC(PULSE_CYC)) u_irq (
    .clk(clk), .rst(rst), .match(match), .im(im), .arst(arst),
    .stat_rd(stat_rd), .clr_req(clr_req), .fout_en(fout_en),
    .fout_in(fout_in), .alm(alm), .irq_n(irq_n)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic clk,
  input logic rst,
  input logic fout_en,
  input logic fout_in,
  input logic irq_n,
  input logic match,
  input logic any_en,
  input logic alm,
  input logic im
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_n && !alm));

  // R3
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alm) |-> $past(match));

  // R4
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    match |-> any_en);

  // R5
  latch_low_chk: assert property (@(posedge clk) disable iff (rst)
    (match && !im && !fout_en) |=> !irq_n);

  // R8
  pulse_low_chk: assert property (@(posedge clk) disable iff (rst)
    (match && im && !fout_en) |=> (!irq_n && alm));

  // R9
  fout_pass_chk: assert property (@(posedge clk) disable iff (rst)
    fout_en |=> (irq_n == $past(fout_in)));
endmodule

bind rtc_alarm_irq rtc_alarm_chk u_chk (
  .clk(clk), .rst(rst), .fout_en(fout_en), .fout_in(fout_in),
  .irq_n(irq_n), .match(match), .any_en(any_en), .alm(alm), .im(im)
);

// File: tb/rtc_alarm_irq_tb.sv
`timescale 1ns/1ps
module rtc_alarm_irq_tb;
  localparam int PC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, fout_en = 1'b0, fout_in = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [41:0] tod = '0;
  logic [7:0] rd_data;
  logic irq_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [6:0] aval [6] = '{7'h30, 7'h45, 7'h11, 7'h01, 7'h12, 7'h03};

  always #2.5 clk = ~clk;

  rtc_alarm_irq #(.PULSE_CYC(PC)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .tod(tod),
    .fout_en(fout_en), .fout_in(fout_in), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic tk(input logic [41:0] t);
    @(negedge clk); tod = t; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [41:0] mk(input logic [6:0] s, input logic [6:0] mi,
      input logic [6:0] h, input logic [6:0] dt, input logic [6:0] mo, input logic [6:0] dw);
    return {dw, mo, dt, h, mi, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [41:0] t;
    int lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d === 8'h00, "R1 reg zero", d, 0);
    end

    // R2: readback
    for (int a = 0; a < 6; a++) begin
      wr(3'(a), 8'(8'h5A + a));
      rd(3'(a), d);
      chk(d === 8'(8'h5A + a), "R2 alarm byte", d, 8'h5A + a);
    end
    wr(3'd6, 8'hFF); rd(3'd6, d); chk(d === 8'h01, "R2 ctrl", d, 1);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'hFF); rd(3'd7, d); chk(d === 8'h80, "R2 status", d, 8'h80);
    wr(3'd7, 8'h00); rd(3'd7, d); chk(d === 8'h00, "R2 status clr", d, 0);

    // R3 R4: sweep of enable masks and mismatch patterns, latched mode
    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 6; f++) wr(3'(f), {m[f], aval[f]});
      for (int dm = 0; dm < 64; dm++) begin
        bit exp;
        for (int f = 0; f < 6; f++) t[f*7 +: 7] = aval[f] ^ {6'd0, dm[f]};
        exp = (m != 0) && ((m & dm) == 0);
        tk(t);
        if (m == 0) chk(irq_n === 1'b1, "R4 no enable", irq_n, 1);
        else chk(irq_n === !exp, "R3 masked match", irq_n, !exp);
        if (exp) wr(3'd7, 8'h00);
      end
    end

    // R3: minute alarm fires on seconds rollover; no match without tick
    wr(3'd0, 8'h00); wr(3'd1, 8'hB0); wr(3'd2, 8'h91);
    wr(3'd3, 8'h81); wr(3'd4, 8'h81); wr(3'd5, 8'h00);
    @(negedge clk); tod = mk(7'h00, 7'h30, 7'h11, 7'h01, 7'h01, 7'h02);
    repeat (5) @(negedge clk);
    chk(irq_n === 1'b1, "R3 no tick", irq_n, 1);
    tk(mk(7'h59, 7'h29, 7'h11, 7'h01, 7'h01, 7'h02));
    chk(irq_n === 1'b1, "R3 before rollover", irq_n, 1);
    tk(mk(7'h00, 7'h30, 7'h11, 7'h01, 7'h01, 7'h02));
    chk(irq_n === 1'b0, "R3 rollover match", irq_n, 0);

    // R5: held low across time and non-matching ticks
    repeat (10) @(negedge clk);
    tk(mk(7'h01, 7'h30, 7'h11, 7'h02, 7'h01, 7'h02));
    chk(irq_n === 1'b0, "R5 held low", irq_n, 0);

    // R6: write 1 no effect, write 0 clears
    wr(3'd7, 8'h01);
    chk(irq_n === 1'b0, "R6 write one kept", irq_n, 0);
    wr(3'd7, 8'h00);
    chk(irq_n === 1'b1, "R6 write zero clears", irq_n, 1);
    rd(3'd7, d); chk(d === 8'h00, "R6 flag clear", d, 0);

    // R7: auto-clear off then on
    t = mk(7'h00, 7'h30, 7'h11, 7'h01, 7'h01, 7'h02);
    tk(t);
    rd(3'd7, d); chk(d === 8'h01, "R7 no auto first", d, 1);
    rd(3'd7, d); chk(d === 8'h01, "R7 no auto kept", d, 1);
    wr(3'd7, 8'h80);
    tk(t);
    rd(3'd7, d); chk(d === 8'h81, "R7 auto read", d, 8'h81);
    chk(irq_n === 1'b1, "R7 auto pin", irq_n, 1);
    rd(3'd7, d); chk(d === 8'h80, "R7 auto cleared", d, 8'h80);
    wr(3'd7, 8'h00);

    // R8: pulse mode, seconds only
    wr(3'd0, 8'hB0); for (int f = 1; f < 6; f++) wr(3'(f), 8'h00);
    wr(3'd6, 8'h01);
    for (int rep = 0; rep < 2; rep++) begin
      tk(mk(7'h30, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00));
      lows = 0;
      for (int k = 0; k < 16; k++) begin
        if (!irq_n) lows++;
        @(negedge clk);
      end
      chk(lows == PC, "R8 pulse width", lows, PC);
    end
    rd(3'd7, d); chk(d === 8'h01, "R8 flag set", d, 1);
    wr(3'd7, 8'h00); wr(3'd6, 8'h00);

    // R9: frequency output owns pin
    @(negedge clk); fout_en = 1'b1; fout_in = 1'b1;
    @(negedge clk); chk(irq_n === 1'b1, "R9 fout high", irq_n, 1);
    fout_in = 1'b0;
    @(negedge clk); chk(irq_n === 1'b0, "R9 fout low", irq_n, 0);
    fout_in = 1'b1;
    tk(mk(7'h30, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00));
    chk(irq_n === 1'b1, "R9 alarm hidden", irq_n, 1);
    rd(3'd7, d); chk(d === 8'h01, "R9 flag set", d, 1);
    @(negedge clk); fout_en = 1'b0;
    @(negedge clk); chk(irq_n === 1'b0, "R9 pin returns", irq_n, 0);
    wr(3'd7, 8'h00);

    // R10: match and clear on the same edge
    @(negedge clk);
    tod = mk(7'h30, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00); tick = 1'b1;
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h00;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk(irq_n === 1'b0, "R10 set wins pin", irq_n, 0);
    rd(3'd7, d); chk(d === 8'h01, "R10 set wins flag", d, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule